// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block serialises one packet onto the D+ and D- lines of a low-speed USB device port, spending twelve system clocks on every bit. A packet is a short byte sequence. The block makes up the sync byte itself and fetches every following byte (the PID, then the payload with its CRC already appended) through a byte read port. Bits go out least significant first with NRZI coding and bit stuffing. The block takes the bus by driving idle J and enabling its drivers. It closes the packet with an end-of-packet sequence and then releases the bus.

There are two request inputs. A data request sends a packet whose byte count, including sync, is given with the strobe. A handshake request needs no buffer: it sends sync and then an ACK or NAK PID. A device address that software has queued is moved into the active address register when a data packet reaches its end of packet. A handshake never moves it, so an address assignment takes effect only after the status data packet has been sent.

Top module: `lsusb_tx`

## Requirements
- R1: After reset, and whenever no packet is in progress, oe_o, dp_o, dm_o and busy_o are all 0 and dev_addr_o is 0 until the first commit.
- R2: The clock edge that accepts a request starts a single preparation cycle with busy_o=1, oe_o=0 and the lines at J (dp_o=0, dm_o=1). On the next edge oe_o rises together with the first bit.
- R3: The first byte on the wire is the sync byte 0x80. Byte k (k>=1) of a data packet is read from rd_data_i while rd_addr_o equals k-1. Every byte goes out bit 0 first, and every bit, stuff bits included, lasts exactly 12 clocks.
- R4: The line symbols are J = (dp_o=0, dm_o=1) and K = (dp_o=1, dm_o=0). A 1 bit keeps the previous symbol and a 0 bit changes it. dp_o and dm_o are never both 1.
- R5: After six consecutive 1 bits an extra 0 bit (a symbol change) is sent and the run count restarts. Runs carry across byte boundaries, and a stuff bit is also sent when a packet's last bits complete a run of six.
- R6: The data request count byte_cnt_i is the total number of bytes including sync. A value below 2 is treated as 2 and a value above 12 as 12.
- R7: After the last bit the block drives SE0 (dp_o=dm_o=0, oe_o=1) for 24 clocks and then J for 12 clocks. On the following edge oe_o, dp_o and dm_o go to 0, busy_o falls, and done_o pulses high for exactly one clock.
- R8: A handshake request sends only sync followed by PID 0xD2 (ACK) when hs_ack_i=1, or 0x5A (NAK) when hs_ack_i=0. It takes priority over a data request in the same cycle.
- R9: At the first SE0 clock of a data packet, dev_addr_o takes the value of pend_addr_i. A handshake leaves dev_addr_o unchanged.
- R10: Data or handshake requests that arrive while busy_o=1 are ignored, and the packet in progress keeps its length and contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 12 per bit |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Data packet request strobe |
| byte_cnt_i | input | 4 | Bytes in the packet including sync |
| hs_req_i | input | 1 | Handshake request strobe |
| hs_ack_i | input | 1 | Handshake type: 1 ACK, 0 NAK |
| rd_addr_o | output | 4 | Buffer read address (byte index minus one) |
| rd_data_i | input | 8 | Buffer read data, combinational from rd_addr_o |
| pend_addr_i | input | 7 | Queued device address |
| dev_addr_o | output | 7 | Active device address |
| dp_o | output | 1 | D+ line drive value |
| dm_o | output | 1 | D- line drive value |
| oe_o | output | 1 | Line driver enable |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | One-clock pulse when the bus is released |

## Verification
A wrong bit index, byte index or run count shows up in the first bit period after the fault, as a wrong symbol at mid-bit or a missing or extra stuff bit. Every later symbol is then shifted, so a fault that touches one bit changes the whole remaining packet and the timing of SE0. A fault in the bit timer or the end-of-packet counter moves the edges of SE0, J and done_o by whole bit times. A wrong commit condition leaves the wrong value on dev_addr_o from the first SE0 clock on.

// File: rtl/lstx_pkg.sv
package lstx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_SEND,
        ST_SE0,
        ST_EOPJ
    } tx_state_e;

    typedef struct packed {
        logic dp;
        logic dm;
        logic oe;
    } bus_drive_t;

    localparam logic [7:0] SYNC_BYTE = 8'h80;
    localparam logic [7:0] PID_ACK   = 8'hD2;
    localparam logic [7:0] PID_NAK   = 8'h5A;
    localparam int         STUFF_RUN = 6;

    // Drive pattern for one symbol; k=1 selects K, k=0 selects J
    function automatic bus_drive_t symbol_drive(input logic k);
        bus_drive_t d;
        d.dp = k;
        d.dm = ~k;
        d.oe = 1'b1;
        return d;
    endfunction

endpackage

// File: rtl/lstx_bit_timer.sv
module lstx_bit_timer #(
    parameter int CLKS_PER_BIT = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic tick
);
    localparam int TW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [TW-1:0] LAST = TW'(CLKS_PER_BIT - 1);

    logic [TW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign tick = (phase == LAST) && !hold;
endmodule

// File: rtl/lstx_serializer.sv
module lstx_serializer
    import lstx_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             step,
    input  logic [CNT_W-1:0] nbytes,
    input  logic [7:0]       next_byte,
    output logic [CNT_W-1:0] byte_idx,
    output logic             line_k,
    output logic             pkt_end
);
    logic [7:0] cur_byte;
    logic [2:0] bit_idx;
    logic [2:0] ones;
    logic       cur_bit;
    logic       stuff_due;

    assign cur_bit   = cur_byte[bit_idx];
    assign stuff_due = (ones == 3'(STUFF_RUN));
    assign pkt_end   = !stuff_due && (byte_idx == nbytes);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            cur_byte <= SYNC_BYTE;
            byte_idx <= '0;
            bit_idx  <= '0;
            ones     <= '0;
            line_k   <= 1'b0;
        end else if (step && !pkt_end) begin
            if (stuff_due) begin
                line_k <= ~line_k;
                ones   <= '0;
            end else begin
                if (!cur_bit) begin
                    line_k <= ~line_k;
                end
                ones <= cur_bit ? ones + 1'b1 : 3'd0;
                if (bit_idx == 3'd7) begin
                    bit_idx  <= '0;
                    byte_idx <= byte_idx + 1'b1;
                    cur_byte <= next_byte;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lsusb_tx.sv
module lsusb_tx
    import lstx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 12,
    parameter int MAX_BYTES    = 12,
    parameter int ADDR_W       = 7,
    parameter int SE0_BITS     = 2,
    parameter int CNT_W        = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  byte_cnt_i,
    input  logic              hs_req_i,
    input  logic              hs_ack_i,
    output logic [CNT_W-1:0]  rd_addr_o,
    input  logic [7:0]        rd_data_i,
    input  logic [ADDR_W-1:0] pend_addr_i,
    output logic [ADDR_W-1:0] dev_addr_o,
    output logic              dp_o,
    output logic              dm_o,
    output logic              oe_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int EW = (SE0_BITS > 1) ? $clog2(SE0_BITS) : 1;
    localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(2);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_BYTES);

    tx_state_e        state;
    logic [CNT_W-1:0] nbytes;
    logic             is_hs;
    logic [7:0]       hs_pid;
    logic [EW-1:0]    se0_cnt;
    logic             tick;
    logic             line_k;
    logic             pkt_end;
    logic [CNT_W-1:0] byte_idx;
    logic [7:0]       next_byte;
    bus_drive_t       drive;

    lstx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) timer_i (
        .clk  (clk),
        .rst  (rst),
        .hold (state == ST_IDLE || state == ST_PREP),
        .tick (tick)
    );

    assign next_byte = is_hs ? hs_pid : rd_data_i;
    assign rd_addr_o = byte_idx;

    lstx_serializer #(.CNT_W(CNT_W)) ser_i (
        .clk       (clk),
        .rst       (rst),
        .init      (state == ST_IDLE),
        .step      ((state == ST_PREP) || (state == ST_SEND && tick)),
        .nbytes    (nbytes),
        .next_byte (next_byte),
        .byte_idx  (byte_idx),
        .line_k    (line_k),
        .pkt_end   (pkt_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            nbytes     <= MIN_CNT;
            is_hs      <= 1'b0;
            hs_pid     <= PID_NAK;
            se0_cnt    <= '0;
            dev_addr_o <= '0;
            done_o     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (hs_req_i) begin
                        is_hs  <= 1'b1;
                        hs_pid <= hs_ack_i ? PID_ACK : PID_NAK;
                        nbytes <= MIN_CNT;
                        state  <= ST_PREP;
                    end else if (start_i) begin
                        is_hs <= 1'b0;
                        if (byte_cnt_i < MIN_CNT) begin
                            nbytes <= MIN_CNT;
                        end else if (byte_cnt_i > MAX_CNT) begin
                            nbytes <= MAX_CNT;
                        end else begin
                            nbytes <= byte_cnt_i;
                        end
                        state <= ST_PREP;
                    end
                end
                ST_PREP: state <= ST_SEND;
                ST_SEND: begin
                    if (tick && pkt_end) begin
                        se0_cnt <= '0;
                        state   <= ST_SE0;
                        if (!is_hs) begin
                            dev_addr_o <= pend_addr_i;
                        end
                    end
                end
                ST_SE0: begin
                    if (tick) begin
                        if (se0_cnt == EW'(SE0_BITS - 1)) begin
                            state <= ST_EOPJ;
                        end else begin
                            se0_cnt <= se0_cnt + 1'b1;
                        end
                    end
                end
                ST_EOPJ: begin
                    if (tick) begin
                        state  <= ST_IDLE;
                        done_o <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_PREP: drive = '{dp: 1'b0, dm: 1'b1, oe: 1'b0};
            ST_SEND: drive = symbol_drive(line_k);
            ST_SE0:  drive = '{dp: 1'b0, dm: 1'b0, oe: 1'b1};
            ST_EOPJ: drive = symbol_drive(1'b0);
            default: drive = '{dp: 1'b0, dm: 1'b0, oe: 1'b0};
        endcase
    end

    assign dp_o   = drive.dp;
    assign dm_o   = drive.dm;
    assign oe_o   = drive.oe;
    assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/lsusb_tx_checker.sv
module lsusb_tx_checker #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] dev_addr_o,
    input logic              dp_o,
    input logic              dm_o,
    input logic              oe_o,
    input logic              busy_o,
    input logic              done_o
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!oe_o && !dp_o && !dm_o));

    assert_prep_j_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (!oe_o && dm_o && !dp_o));

    assert_oe_after_prep_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_o) |-> $past(busy_o && !oe_o && dm_o));

    assert_no_se1_R4: assert property (@(posedge clk) disable iff (rst)
        !(dp_o && dm_o));

    assert_release_after_j_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!oe_o && !busy_o && $past(oe_o && dm_o && !dp_o)));

    assert_addr_at_se0_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(dev_addr_o) |-> (oe_o && !dp_o && !dm_o && $past(dp_o || dm_o)));
endmodule

bind lsusb_tx lsusb_tx_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .dev_addr_o (dev_addr_o),
    .dp_o       (dp_o),
    .dm_o       (dm_o),
    .oe_o       (oe_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/lsusb_tx_tb_top.sv
module lsusb_tx_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [3:0] byte_cnt_i = '0;
    logic       hs_req_i = 1'b0;
    logic       hs_ack_i = 1'b0;
    logic [3:0] rd_addr_o;
    logic [7:0] rd_data_i;
    logic [6:0] pend_addr_i = '0;
    logic [6:0] dev_addr_o;
    logic       dp_o, dm_o, oe_o, busy_o, done_o;

    logic [7:0] mem [0:15];
    logic [7:0] exp_b [0:11];
    logic       exp_sym [0:127];
    int         exp_nbits;
    int         exp_nb;
    logic [6:0] exp_addr;
    int         tests = 0;
    int         fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    assign rd_data_i = mem[rd_addr_o];

    lsusb_tx dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .byte_cnt_i(byte_cnt_i),
        .hs_req_i(hs_req_i), .hs_ack_i(hs_ack_i), .rd_addr_o(rd_addr_o),
        .rd_data_i(rd_data_i), .pend_addr_i(pend_addr_i), .dev_addr_o(dev_addr_o),
        .dp_o(dp_o), .dm_o(dm_o), .oe_o(oe_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected symbol list (1=K, 0=J) from bytes, with NRZI and stuffing
    task automatic build_expected();
        logic lvl = 1'b0;
        int   ones = 0;
        exp_nbits = 0;
        for (int i = 0; i < exp_nb; i++) begin
            for (int j = 0; j < 8; j++) begin
                if (!exp_b[i][j]) lvl = ~lvl;
                ones = exp_b[i][j] ? ones + 1 : 0;
                exp_sym[exp_nbits] = lvl;
                exp_nbits++;
                if (ones == 6) begin
                    lvl = ~lvl;
                    exp_sym[exp_nbits] = lvl;
                    exp_nbits++;
                    ones = 0;
                end
            end
        end
    endtask

    task automatic run_packet(input int n, input bit do_start, input bit do_hs,
                              input bit ack, input bit inject);
        int last;
        exp_b[0] = 8'h80;
        if (do_hs) begin
            exp_nb = 2;
            exp_b[1] = ack ? 8'hD2 : 8'h5A;
        end else begin
            exp_nb = (n < 2) ? 2 : ((n > 12) ? 12 : n);
            for (int i = 1; i < exp_nb; i++) exp_b[i] = mem[i-1];
            exp_addr = pend_addr_i;
        end
        build_expected();
        @(negedge clk);
        start_i = do_start;
        hs_req_i = do_hs;
        hs_ack_i = ack;
        byte_cnt_i = 4'(n);
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        hs_req_i = 1'b0;
        check("R2 prep busy/oe/dp/dm", {12'd0, busy_o, oe_o, dp_o, dm_o}, 16'b1001);
        last = 12 * (exp_nbits + 3);
        for (int c = 0; c <= last + 1; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (inject && c == 30) begin
                start_i = 1'b1; hs_req_i = 1'b1; byte_cnt_i = 4'd12;
            end
            if (inject && c == 31) begin
                start_i = 1'b0; hs_req_i = 1'b0;
            end
            if (c < 12 * exp_nbits) begin
                if (c % 12 == 6)
                    check(inject ? "R10 bit symbol" : "R3 R4 R5 bit symbol",
                          {13'd0, oe_o, dp_o, dm_o},
                          {13'd0, 1'b1, exp_sym[c/12], ~exp_sym[c/12]});
            end else if (c < 12 * exp_nbits + 24) begin
                if (c % 12 == 0 || c % 12 == 11)
                    check("R7 SE0", {13'd0, oe_o, dp_o, dm_o}, 16'b100);
            end else if (c < last) begin
                if (c % 12 == 6 || c % 12 == 11)
                    check("R7 J after SE0", {13'd0, oe_o, dp_o, dm_o}, 16'b101);
            end else if (c == last) begin
                check("R7 release", {11'd0, oe_o, dp_o, dm_o, busy_o, done_o}, 16'b00001);
                check("R9 device address", {9'd0, dev_addr_o}, {9'd0, exp_addr});
            end else begin
                check("R7 done one clock", {15'd0, done_o}, 16'd0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4711);
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        exp_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 idle after reset", {10'd0, oe_o, dp_o, dm_o, busy_o, done_o, 1'b0}, 16'd0);
        check("R1 address after reset", {9'd0, dev_addr_o}, 16'd0);

        // R5: runs of ones spanning bytes and ending the packet
        mem[0] = 8'hC3; mem[1] = 8'hFF; mem[2] = 8'hFF;
        pend_addr_i = 7'h15;
        run_packet(4, 1'b1, 1'b0, 1'b0, 1'b0);

        // R8: handshakes, address must stay
        pend_addr_i = 7'h2A;
        run_packet(0, 1'b0, 1'b1, 1'b1, 1'b0);
        run_packet(0, 1'b0, 1'b1, 1'b0, 1'b0);
        // R8: handshake wins over simultaneous data request
        run_packet(9, 1'b1, 1'b1, 1'b1, 1'b0);

        // R6: count clamping
        mem[0] = 8'h4B;
        pend_addr_i = 7'h01;
        run_packet(0, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 12; i++) mem[i] = 8'($urandom);
        pend_addr_i = 7'h7F;
        run_packet(15, 1'b1, 1'b0, 1'b0, 1'b0);

        // R10: requests while busy are ignored
        pend_addr_i = 7'h33;
        run_packet(3, 1'b1, 1'b0, 1'b0, 1'b1);

        // random packets
        for (int p = 0; p < 8; p++) begin
            for (int i = 0; i < 12; i++)
                mem[i] = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
            pend_addr_i = 7'($urandom);
            run_packet(2 + int'($urandom % 11), 1'b1, 1'b0, 1'b0, 1'b0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule